// File: doc/BRIEF.md
# Three-Channel Match and Overflow Timer

This peripheral holds three independent counters behind a small word-addressed register bus. Each channel has a live count, a reload value and two compare values. A channel counts up or down, one step per bus clock or one step per rising edge of a shared external tick. When it runs past the end of its range, it reloads from its reload register and reports an overflow event. Each time a step lands on one of its compare values, it reports a match event.

The nine events set sticky bits in a shared status register. Software clears those bits by writing ones. A shared mask register and the per-channel interrupt-enable bits decide which pending bits drive the single interrupt line. Typical uses are a free-running time base (up-counting, reload 0), a periodic tick (count and reload preset to top minus period plus one), and one-shot deadlines built on a compare register.

Top module: `triple_timer`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0 and `irq` is low.
- R2: Word address 4n+k selects channel n (n = 0..2): k=0 count, k=1 reload, k=2 compare A, k=3 compare B. Word 12 is control, 13 is status and 14 is mask. Every other word reads 0. In control, channel n has run enable at bit 3n, tick source at bit 3n+1 (1 = external) and interrupt enable at bit 3n+2, and bit 9+n selects up-counting. In status and mask, channel n has compare A at bit 3n, compare B at bit 3n+1 and overflow at bit 3n+2.
- R3: A running up-counting channel on the bus clock adds 1 per cycle. A step taken from all-ones loads the reload value instead and sets the channel's overflow status bit.
- R4: A running down-counting channel subtracts 1 per cycle. A step taken from 0 loads the reload value instead and sets the channel's overflow status bit.
- R5: A step whose new count equals compare A or compare B sets the matching status bit. The compare value used is the one held before that cycle.
- R6: A write to a count register takes effect at the next edge and overrides any step in that cycle. A read returns the live count. A channel whose run enable is clear holds its count.
- R7: Status bits are sticky. Writing a 1 clears a bit and writing a 0 leaves it alone. An event in the same cycle as its clear leaves the bit set.
- R8: `irq` is high exactly when some status bit is set, its mask bit is 0, and its channel's interrupt enable is 1.
- R9: With the external tick selected, a channel steps once for each rising edge of `ext_tick`, seen through a two-flop synchronizer. It steps two edges after the first clock edge that samples the tick high. Otherwise it holds.
- R10: With count and reload both preset to all-ones minus (P-1), an up-counting channel sets its overflow bit every P cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ext_tick | input | 1 | Asynchronous external tick |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default 32-bit counters. All-ones is reached by writing the count register near the top, so wrap, reload and the P-cycle period are exercised in a handful of cycles. No long run is needed. A behavioural model predicts every register and the interrupt line on each clock. Directed sequences add exact-cycle checks for clear-versus-event collisions, count overrides and synchronizer latency.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int NCH    = 3;
    localparam int EVW    = 3;
    localparam int CTRL_W = 12;
    localparam int ST_W   = NCH * EVW;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'd12;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd13;
    localparam logic [ADDR_W-1:0] A_MASK = 4'd14;

    typedef enum logic [1:0] {
        F_COUNT  = 2'd0,
        F_RELOAD = 2'd1,
        F_CMPA   = 2'd2,
        F_CMPB   = 2'd3
    } field_e;

    typedef struct packed {
        logic up;
        logic ie;
        logic ext_clk;
        logic run;
    } ch_cfg_t;

    // packed so that hit_a lands on bit 3n, hit_b on 3n+1, wrap on 3n+2
    typedef struct packed {
        logic wrap;
        logic hit_b;
        logic hit_a;
    } ch_evt_t;

    function automatic ch_cfg_t cfg_of(input logic [CTRL_W-1:0] c, input int n);
        ch_cfg_t r;
        r.run     = c[3*n];
        r.ext_clk = c[3*n+1];
        r.ie      = c[3*n+2];
        r.up      = c[9+n];
        return r;
    endfunction
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync (
    input  logic clk,
    input  logic rst,
    input  logic tick_in,
    output logic tick_rise
);
    logic [2:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) pipe_q <= '0;
        else     pipe_q <= {pipe_q[1:0], tick_in};
    end

    assign tick_rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  ch_cfg_t       cfg,
    input  logic          tick_rise,
    input  logic [3:0]    wr_f,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt_o,
    output logic [CW-1:0] reload_o,
    output logic [CW-1:0] cmpa_o,
    output logic [CW-1:0] cmpb_o,
    output ch_evt_t       evt_o
);
    localparam logic [CW-1:0] TOP = '1;

    logic [CW-1:0] cnt_q, reload_q, cmpa_q, cmpb_q;
    logic [CW-1:0] step_v, nxt_v;
    logic          advance, at_end;

    always_comb begin
        advance = cfg.run && (cfg.ext_clk ? tick_rise : 1'b1) && !wr_f[F_COUNT];
        at_end  = cfg.up ? (cnt_q == TOP) : (cnt_q == '0);
        step_v  = cfg.up ? cnt_q + 1'b1 : cnt_q - 1'b1;
        nxt_v   = at_end ? reload_q : step_v;
        evt_o.wrap  = advance && at_end;
        evt_o.hit_a = advance && (nxt_v == cmpa_q);
        evt_o.hit_b = advance && (nxt_v == cmpb_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            reload_q <= '0;
            cmpa_q   <= '0;
            cmpb_q   <= '0;
        end else begin
            if (wr_f[F_COUNT])  cnt_q    <= wdata;
            else if (advance)   cnt_q    <= nxt_v;
            if (wr_f[F_RELOAD]) reload_q <= wdata;
            if (wr_f[F_CMPA])   cmpa_q   <= wdata;
            if (wr_f[F_CMPB])   cmpb_q   <= wdata;
        end
    end

    assign cnt_o    = cnt_q;
    assign reload_o = reload_q;
    assign cmpa_o   = cmpa_q;
    assign cmpb_o   = cmpb_q;
endmodule

// File: rtl/triple_timer.sv
module triple_timer
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    logic                  wr;
    logic                  tick_rise;
    logic [CTRL_W-1:0]     ctrl_q;
    logic [ST_W-1:0]       status_q, mask_q, evt_all, ie_exp, clr_v;
    logic [NCH*CW-1:0]     cnt_flat, reload_flat, cmpa_flat, cmpb_flat;

    assign wr = bus_en && bus_we;

    tmr_tick_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .tick_in  (ext_tick),
        .tick_rise(tick_rise)
    );

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_ch
            logic [3:0] wr_f;
            ch_cfg_t    cfg;
            ch_evt_t    evt;

            assign cfg = cfg_of(ctrl_q, n);
            always_comb begin
                wr_f = '0;
                if (wr && bus_addr[3:2] == 2'(n))
                    wr_f[bus_addr[1:0]] = 1'b1;
            end

            tmr_channel #(.CW(CW)) u_ch (
                .clk      (clk),
                .rst      (rst),
                .cfg      (cfg),
                .tick_rise(tick_rise),
                .wr_f     (wr_f),
                .wdata    (bus_wdata[CW-1:0]),
                .cnt_o    (cnt_flat[n*CW +: CW]),
                .reload_o (reload_flat[n*CW +: CW]),
                .cmpa_o   (cmpa_flat[n*CW +: CW]),
                .cmpb_o   (cmpb_flat[n*CW +: CW]),
                .evt_o    (evt)
            );

            assign evt_all[n*EVW +: EVW] = evt;
            assign ie_exp[n*EVW +: EVW]  = {EVW{cfg.ie}};
        end
    endgenerate

    assign clr_v = (wr && bus_addr == A_STAT) ? bus_wdata[ST_W-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            if (wr && bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (wr && bus_addr == A_MASK) mask_q <= bus_wdata[ST_W-1:0];
            status_q <= (status_q & ~clr_v) | evt_all;
        end
    end

    always_comb begin
        logic [1:0] ci;
        ci = bus_addr[3:2];
        bus_rdata = '0;
        if (bus_addr < A_CTRL) begin
            case (field_e'(bus_addr[1:0]))
                F_COUNT:  bus_rdata[CW-1:0] = cnt_flat[ci*CW +: CW];
                F_RELOAD: bus_rdata[CW-1:0] = reload_flat[ci*CW +: CW];
                F_CMPA:   bus_rdata[CW-1:0] = cmpa_flat[ci*CW +: CW];
                default:  bus_rdata[CW-1:0] = cmpb_flat[ci*CW +: CW];
            endcase
        end else if (bus_addr == A_CTRL) begin
            bus_rdata[CTRL_W-1:0] = ctrl_q;
        end else if (bus_addr == A_STAT) begin
            bus_rdata[ST_W-1:0] = status_q;
        end else if (bus_addr == A_MASK) begin
            bus_rdata[ST_W-1:0] = mask_q;
        end
    end

    assign irq = |(status_q & ~mask_q & ie_exp);
endmodule

// File: rtl/triple_timer_chk.sv
module triple_timer_chk
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_en,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CTRL_W-1:0] ctrl_q,
    input logic [ST_W-1:0]   status_q,
    input logic [ST_W-1:0]   mask_q,
    input logic [NCH*CW-1:0] cnt_flat,
    input logic              irq
);
    logic rst_d;
    always_ff @(posedge clk) rst_d <= rst;

    // R1
    always @(posedge clk) begin
        if (rst_d) begin
            reset_zero_chk: assert (ctrl_q == '0 && status_q == '0 && mask_q == '0
                                    && cnt_flat == '0 && !irq);
        end
    end

    // R7
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_en && bus_we && bus_addr == A_STAT)
        |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R8
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((status_q & ~mask_q) != '0));

    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        ((status_q & ~mask_q) == '0) |-> !irq);

    generate
        for (genvar n = 0; n < NCH; n++) begin : g_chk
            logic cw_n;
            assign cw_n = bus_en && bus_we && bus_addr == ADDR_W'(4*n);

            // R6
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                (!ctrl_q[3*n] && !cw_n) |=> $stable(cnt_flat[n*CW +: CW]));

            // R3
            up_step_chk: assert property (@(posedge clk) disable iff (rst)
                (ctrl_q[3*n] && ctrl_q[9+n] && !ctrl_q[3*n+1] && !cw_n
                 && cnt_flat[n*CW +: CW] != '1)
                |=> (cnt_flat[n*CW +: CW] == $past(cnt_flat[n*CW +: CW]) + CW'(1)));
        end
    endgenerate
endmodule

bind triple_timer triple_timer_chk #(.CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .bus_en  (bus_en),
    .bus_we  (bus_we),
    .bus_addr(bus_addr),
    .ctrl_q  (ctrl_q),
    .status_q(status_q),
    .mask_q  (mask_q),
    .cnt_flat(cnt_flat),
    .irq     (irq)
);

// File: tb/triple_timer_tb.sv
`timescale 1ns/1ps
module triple_timer_tb;
    logic        clk = 0;
    logic        rst = 1;
    logic        bus_en = 0, bus_we = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        ext_tick = 0;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    triple_timer u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_tick(ext_tick), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    logic [31:0] mc[3], ml[3], ma[3], mb[3];
    logic [11:0] mctrl;
    logic [8:0]  mst, mmask, mev, mclr;
    logic        ms1, ms2, ms3, mrise, madv, mwrap;
    logic [31:0] mnv;

    always @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < 3; n++) begin mc[n] = 0; ml[n] = 0; ma[n] = 0; mb[n] = 0; end
            mctrl = 0; mst = 0; mmask = 0; ms1 = 0; ms2 = 0; ms3 = 0;
        end else begin
            mrise = ms2 && !ms3;
            ms3 = ms2; ms2 = ms1; ms1 = ext_tick;
            mev = 0;
            for (int n = 0; n < 3; n++) begin
                madv = mctrl[3*n] && (mctrl[3*n+1] ? mrise : 1'b1)
                       && !(bus_en && bus_we && bus_addr == 4*n);
                if (madv) begin
                    if (mctrl[9+n]) begin
                        mwrap = (mc[n] == 32'hFFFF_FFFF);
                        mnv = mwrap ? ml[n] : mc[n] + 1;
                    end else begin
                        mwrap = (mc[n] == 0);
                        mnv = mwrap ? ml[n] : mc[n] - 1;
                    end
                    mev[3*n+2] = mwrap;
                    mev[3*n]   = (mnv == ma[n]);
                    mev[3*n+1] = (mnv == mb[n]);
                    mc[n] = mnv;
                end
            end
            mclr = 0;
            if (bus_en && bus_we) begin
                if (bus_addr < 12) begin
                    case (bus_addr[1:0])
                        2'd0: mc[bus_addr[3:2]] = bus_wdata;
                        2'd1: ml[bus_addr[3:2]] = bus_wdata;
                        2'd2: ma[bus_addr[3:2]] = bus_wdata;
                        default: mb[bus_addr[3:2]] = bus_wdata;
                    endcase
                end else if (bus_addr == 12) mctrl = bus_wdata[11:0];
                else if (bus_addr == 13) mclr = bus_wdata[8:0];
                else if (bus_addr == 14) mmask = bus_wdata[8:0];
            end
            mst = (mst & ~mclr) | mev;
        end
    end

    function automatic logic [31:0] mread(input logic [3:0] a);
        if (a < 12) begin
            case (a[1:0])
                2'd0: return mc[a[3:2]];
                2'd1: return ml[a[3:2]];
                2'd2: return ma[a[3:2]];
                default: return mb[a[3:2]];
            endcase
        end
        if (a == 12) return {20'd0, mctrl};
        if (a == 13) return {23'd0, mst};
        if (a == 14) return {23'd0, mmask};
        return 0;
    endfunction

    function automatic logic mirq();
        logic [8:0] ie;
        for (int n = 0; n < 3; n++) ie[3*n +: 3] = {3{mctrl[3*n+2]}};
        return |(mst & ~mmask & ie);
    endfunction

    // per-cycle comparison against the model
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            checks++;
            if (bus_rdata !== mread(bus_addr)) begin
                errors++;
                $display("FAIL %s model rdata addr %0d got %h exp %h",
                         (bus_addr < 12) ? "R3" : ((bus_addr == 13) ? "R7" : "R2"),
                         bus_addr, bus_rdata, mread(bus_addr));
            end
            checks++;
            if (irq !== mirq()) begin
                errors++;
                $display("FAIL R8 model irq got %b exp %b", irq, mirq());
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1; bus_we = 0; bus_addr = a;
        @(posedge clk); #1;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic idle(input logic e);
        @(negedge clk);
        bus_en = 0; bus_we = 0; ext_tick = e;
        @(posedge clk); #1;
    endtask

    task automatic irq_chk(input logic exp, input string tag);
        idle(ext_tick);
        chk(tag, {31'd0, irq}, {31'd0, exp});
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state, R2 unused word reads 0
        for (int a = 0; a < 16; a++) rd_chk(4'(a), 32'h0, (a == 15) ? "R2 unused" : "R1 reset");
        chk("R1 irq reset", {31'd0, irq}, 32'd0);

        // R2 register map
        for (int n = 0; n < 3; n++) begin
            wr(4'(4*n+1), 32'h1000_0000 + n);
            wr(4'(4*n+2), 32'hA0 + n);
            wr(4'(4*n+3), 32'hB0 + n);
        end
        for (int n = 0; n < 3; n++) begin
            rd_chk(4'(4*n+1), 32'h1000_0000 + n, "R2 reload");
            rd_chk(4'(4*n+2), 32'hA0 + n, "R2 cmpA");
            rd_chk(4'(4*n+3), 32'hB0 + n, "R2 cmpB");
        end
        wr(14, 32'hFFFF_FFFF);
        rd_chk(14, 32'h1FF, "R2 mask width");
        wr(12, 32'hFFFF_FFFF);
        rd_chk(12, 32'hFFF, "R2 ctrl width");
        wr(12, 0);
        wr(13, 32'h1FF);
        wr(14, 0);

        // R3 up-count wrap
        wr(0, 32'hFFFF_FFFD);
        wr(1, 5);
        wr(12, 32'h201);
        rd_chk(0, 32'hFFFF_FFFE, "R3 step");
        rd_chk(0, 32'hFFFF_FFFF, "R3 step");
        rd_chk(13, 32'h004, "R3 overflow");
        rd_chk(0, 6, "R3 reload");
        // R5 compare hits
        wr(2, 10);
        wr(3, 12);
        rd_chk(13, 32'h004, "R5 before hit");
        rd_chk(13, 32'h005, "R5 cmpA hit");
        rd_chk(0, 11, "R6 live count");
        rd_chk(13, 32'h007, "R5 cmpB hit");
        // R7 clear and collision
        wr(13, 32'h004);
        rd_chk(13, 32'h003, "R7 w1c");
        wr(0, 100);
        wr(2, 102);
        wr(13, 32'h001);
        rd_chk(13, 32'h003, "R7 event wins");
        wr(13, 32'h003);
        rd_chk(13, 32'h000, "R7 cleared");
        // R6 overriding write, disable holds
        wr(0, 32'h55);
        rd_chk(0, 32'h56, "R6 write override");
        wr(12, 0);
        rd_chk(0, 32'h57, "R6 stop");
        rd_chk(0, 32'h57, "R6 hold");

        // R4 down-count wrap
        wr(13, 32'h1FF);
        wr(8, 2);
        wr(9, 7);
        wr(12, 32'h040);
        rd_chk(8, 1, "R4 step");
        rd_chk(8, 0, "R4 step");
        rd_chk(13, 32'h100, "R4 overflow");
        rd_chk(8, 6, "R4 reload");

        // R8 interrupt gating
        wr(12, 32'h100);
        irq_chk(1, "R8 enabled");
        wr(14, 32'h100);
        irq_chk(0, "R8 masked");
        wr(14, 32'h0FF);
        irq_chk(1, "R8 other mask bits");
        wr(12, 32'h004);
        irq_chk(0, "R8 wrong channel ie");
        wr(12, 32'h100);
        wr(13, 32'h100);
        irq_chk(0, "R8 cleared");
        wr(14, 0);

        // R9 external tick
        wr(4, 0);
        wr(13, 32'h1FF);
        wr(12, 32'h418);
        for (int p = 0; p < 4; p++) begin
            repeat (3) idle(1);
            repeat (3) idle(0);
        end
        repeat (4) idle(0);
        rd_chk(4, 4, "R9 tick count");
        repeat (10) idle(0);
        rd_chk(4, 4, "R9 hold without tick");

        // R10 periodic overflow, P = 7
        wr(12, 32'h840);
        wr(9, 32'hFFFF_FFF9);
        wr(13, 32'h1FF);
        wr(8, 32'hFFFF_FFF9);
        for (int i = 1; i <= 16; i++) begin
            if (i == 8) wr(13, 32'h100);
            else begin
                rd(13, v);
                chk("R10 period", {31'd0, v[8]},
                    {31'd0, (i == 7) || (i >= 14)});
            end
        end

        idle(0);
        idle(0);
        finish_run();
    end
endmodule